// File: doc/BRIEF.md
# Free-Address Sink Routing Switch

This block is one two-by-two element of a buffered network that carries addresses of free memory cells from storage banks back toward the processing elements. Because the addresses are streamed ahead of demand, an allocation request at a processing element can be served in a single cycle. The element keeps a small holding queue of free addresses for each of its two downstream sides. Whenever an address leaves a queue, that side is refilled from the upstream inputs.

Each downstream side normally refills from the upstream input directly across from it. This keeps allocations local. When a side is close to running dry and its own input has nothing to offer, it may take an address from the other input. It does so only if the other input is not already being taken by its own straight path. Heavy allocation therefore spreads across the network instead of piling onto one bank. All four edges use a valid/ready handshake. Each address is 24 bits wide.

Top module: `free_addr_sink_switch`

## Requirements
- R1: While reset is held, and in the cycle after it is released, both downstream valid outputs are low.
- R2: Downstream side k (k = 0, 1) shows valid exactly when its queue holds at least one address. It presents the oldest queued address. Addresses leave in first-in, first-out order, and one is removed on each cycle where valid and ready are both high.
- R3: Straight path: upstream input k is input 0 for side 0 and input 1 for side 1. When input k is valid and queue k holds fewer than 4 entries, input k is accepted into queue k (ready high in the same cycle). A pop from the queue in that same cycle does not count as free space.
- R4: Crossed refill: side k takes the address from input 1-k when all of the following hold: queue k holds at most 1 entry, input k is not valid, input 1-k is valid, queue k holds fewer than 4 entries, and input 1-k is not being accepted by its own straight path.
- R5: A queue that holds 2 or more entries never takes an address from its crossed input.
- R6: The straight claim wins. An input whose own queue has space is never routed across, and a side whose straight input is valid never takes the crossed input.
- R7: Upstream ready is high only for a valid input that has a destination with space. Otherwise the input is held. Each queue holds at most 4 entries.
- R8: No address is dropped or duplicated. The sequence seen on each downstream side equals the accepted addresses routed to it, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| up_valid | input | 2 | Upstream address offered, bit k for input k |
| up_ready | output | 2 | Upstream address accepted this cycle |
| up_addr | input | 2x24 | Upstream free-cell addresses, index k for input k |
| dn_valid | output | 2 | Downstream address available, bit k for side k |
| dn_ready | input | 2 | Downstream consumer takes the address |
| dn_addr | output | 2x24 | Oldest queued address per side |

## Verification
The bench sweeps every combination of the two upstream valid bits and the two downstream ready bits. It runs these through phases that bias the consumers toward idle, busy or absent, so that each queue passes through every occupancy from empty to full. Phases with ready mostly low fill the queues. They separate the straight-path acceptance from the full-queue hold. Phases with one input silent while its side drains exercise the crossed refill and its blocking by the other side's straight claim. A queue model in the bench tracks every address end to end, which exposes any dropped, repeated or reordered address.

// File: rtl/fas_pkg.sv
package fas_pkg;
    parameter int ADDR_W    = 24;
    parameter int Q_DEPTH   = 4;
    parameter int LOW_MARK  = 1;
    parameter int NPORTS    = 2;
endpackage

// File: rtl/addr_fifo.sv
module addr_fifo #(
    parameter int AW    = 24,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [CW-1:0] occ,
    output logic [AW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wp] = push_addr;
            st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + 1'b1;
        end
        if (pop) begin
            st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.wp  <= '0;
            st_q.rp  <= '0;
            st_q.cnt <= '0;
            st_q.mem <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign occ  = st_q.cnt;
    assign head = st_q.mem[st_q.rp];
endmodule

// File: rtl/refill_arb.sv
module refill_arb #(
    parameter int DEPTH    = 4,
    parameter int LOW_MARK = 1,
    parameter int CW       = $clog2(DEPTH + 1)
) (
    input  logic [1:0]         in_valid,
    input  logic [1:0][CW-1:0] occ,
    output logic [1:0]         take_straight,
    output logic [1:0]         take_cross,
    output logic [1:0]         in_ready
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] LOW  = CW'(LOW_MARK);

    logic [1:0] has_space;
    logic [1:0] starving;

    always_comb begin
        for (int k = 0; k < 2; k++) begin
            has_space[k]     = occ[k] < FULL;
            starving[k]      = occ[k] <= LOW;
            take_straight[k] = in_valid[k] && has_space[k];
        end
        for (int k = 0; k < 2; k++) begin
            take_cross[k] = starving[k] && has_space[k] && !in_valid[k]
                         && in_valid[1-k] && !take_straight[1-k];
        end
        for (int k = 0; k < 2; k++) begin
            in_ready[k] = take_straight[k] || take_cross[1-k];
        end
    end
endmodule

// File: rtl/free_addr_sink_switch.sv
module free_addr_sink_switch
    import fas_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DEPTH    = Q_DEPTH,
    parameter int LOWM     = LOW_MARK
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         up_valid,
    output logic [1:0]         up_ready,
    input  logic [1:0][AW-1:0] up_addr,
    output logic [1:0]         dn_valid,
    input  logic [1:0]         dn_ready,
    output logic [1:0][AW-1:0] dn_addr
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0][CW-1:0] occ;
    logic [1:0]         take_straight;
    logic [1:0]         take_cross;
    logic [1:0]         push;
    logic [1:0]         pop;
    logic [1:0][AW-1:0] push_addr;

    refill_arb #(.DEPTH(DEPTH), .LOW_MARK(LOWM), .CW(CW)) u_arb (
        .in_valid      (up_valid),
        .occ           (occ),
        .take_straight (take_straight),
        .take_cross    (take_cross),
        .in_ready      (up_ready)
    );

    for (genvar k = 0; k < 2; k++) begin : g_side
        assign push[k]      = take_straight[k] || take_cross[k];
        assign push_addr[k] = take_straight[k] ? up_addr[k] : up_addr[1-k];
        assign dn_valid[k]  = occ[k] != '0;
        assign pop[k]       = dn_valid[k] && dn_ready[k];

        addr_fifo #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_q (
            .clk       (clk),
            .rst       (rst),
            .push      (push[k]),
            .push_addr (push_addr[k]),
            .pop       (pop[k]),
            .occ       (occ[k]),
            .head      (dn_addr[k])
        );
    end
endmodule

// File: rtl/free_addr_sink_switch_chk.sv
module free_addr_sink_switch_chk #(
    parameter int AW    = 24,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic [1:0]         up_valid,
    input logic [1:0]         up_ready,
    input logic [1:0]         dn_valid,
    input logic [1:0]         dn_ready,
    input logic [1:0][AW-1:0] dn_addr,
    input logic [1:0][CW-1:0] occ
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    for (genvar k = 0; k < 2; k++) begin : g_chk
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            occ[k] <= FULL); // R7
        AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
            up_ready[k] |-> up_valid[k]); // R7
        AST_STRAIGHT_TAKEN: assert property (@(posedge clk) disable iff (rst)
            (up_valid[k] && occ[k] < FULL) |-> up_ready[k]); // R3
        AST_CROSS_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
            (up_ready[k] && occ[k] == FULL) |-> occ[1-k] <= CW'(1)); // R5
        AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (rst)
            (dn_valid[k] && !dn_ready[k]) |=> (dn_valid[k] && $stable(dn_addr[k]))); // R2
        AST_EMPTY_AFTER_RESET: assert property (@(posedge clk)
            rst |=> !dn_valid[k]); // R1
    end
endmodule

bind free_addr_sink_switch free_addr_sink_switch_chk #(.AW(AW), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .up_valid (up_valid),
    .up_ready (up_ready),
    .dn_valid (dn_valid),
    .dn_ready (dn_ready),
    .dn_addr  (dn_addr),
    .occ      (occ)
);

// File: tb/sim_free_addr_sink_switch.sv
`timescale 1ns/1ps
module sim_free_addr_sink_switch;
    localparam int AW = 24;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [1:0]         up_valid = '0;
    logic [1:0]         up_ready;
    logic [1:0][AW-1:0] up_addr = '0;
    logic [1:0]         dn_valid;
    logic [1:0]         dn_ready = '0;
    logic [1:0][AW-1:0] dn_addr;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    logic [AW-1:0] q0[$];
    logic [AW-1:0] q1[$];
    logic [AW-1:0] nxt [2];
    int sent = 0;
    int rcvd = 0;

    always #2.5 clk = ~clk;

    free_addr_sink_switch u0 (
        .clk(clk), .rst(rst),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int qsize(input int k);
        return (k == 0) ? q0.size() : q1.size();
    endfunction

    // one cycle: drive at negedge, check before posedge, update model after it
    task automatic step(input logic [1:0] iv, input logic [1:0] ordy);
        int cnt [2];
        bit sp [2], st [2], cr [2], er [2], pop [2];
        string tag;
        @(negedge clk);
        up_valid   = iv;
        dn_ready   = ordy;
        up_addr[0] = nxt[0];
        up_addr[1] = nxt[1];
        #1;
        for (int k = 0; k < 2; k++) begin
            cnt[k] = qsize(k);
            sp[k]  = cnt[k] < 4;
            st[k]  = iv[k] && sp[k];
        end
        for (int k = 0; k < 2; k++)
            cr[k] = (cnt[k] <= 1) && sp[k] && !iv[k] && iv[1-k] && !st[1-k];
        for (int k = 0; k < 2; k++) begin
            er[k] = st[k] || cr[1-k];
            if (st[k])                                   tag = "R3";
            else if (cr[1-k])                            tag = "R4";
            else if (!iv[k])                             tag = "R7";
            else if (iv[1-k] && sp[1-k] && cnt[1-k] <= 1) tag = "R6";
            else if (cnt[1-k] >= 2)                      tag = "R5";
            else                                         tag = "R7";
            chk(tag, $sformatf("up_ready[%0d]", k), 32'(up_ready[k]), 32'(er[k]));
            chk("R2", $sformatf("dn_valid[%0d]", k), 32'(dn_valid[k]), 32'(cnt[k] > 0));
            if (cnt[k] > 0)
                chk("R8", $sformatf("dn_addr[%0d]", k), 32'(dn_addr[k]),
                    32'((k == 0) ? q0[0] : q1[0]));
            pop[k] = (cnt[k] > 0) && ordy[k];
        end
        @(posedge clk);
        if (pop[0]) begin void'(q0.pop_front()); rcvd++; end
        if (pop[1]) begin void'(q1.pop_front()); rcvd++; end
        if (st[0]) q0.push_back(nxt[0]);
        if (cr[0]) q0.push_back(nxt[1]);
        if (st[1]) q1.push_back(nxt[1]);
        if (cr[1]) q1.push_back(nxt[0]);
        for (int k = 0; k < 2; k++)
            if (er[k]) begin nxt[k] = nxt[k] + 1'b1; sent++; end
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [1:0]  iv, ordy;
        nxt[0] = 24'h100000;
        nxt[1] = 24'h200000;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "dn_valid during reset", 32'(dn_valid), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "dn_valid after reset", 32'(dn_valid), 32'd0);

        // exhaustive sweep of the 16 valid/ready combinations per occupancy start
        for (int fill = 0; fill < 5; fill++) begin
            for (int pat = 0; pat < 16; pat++) begin
                repeat (fill) step(2'b11, 2'b00);
                step(pat[1:0], pat[3:2]);
                repeat (6) step(2'b00, 2'b11);
            end
        end

        // crossed refill: input 1 silent while side 1 drains
        repeat (8) step(2'b01, 2'b10);
        // side 0 full, input 0 crosses to starving side 1
        repeat (6) step(2'b01, 2'b00);
        repeat (6) step(2'b00, 2'b11);

        // biased pseudo-random phases
        lfsr = 16'hACE1;
        for (int ph = 0; ph < 8; ph++) begin
            for (int c = 0; c < 400; c++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (ph % 4)
                    0: begin iv = lfsr[1:0];             ordy = lfsr[3:2]; end
                    1: begin iv = lfsr[1:0] | lfsr[5:4]; ordy = lfsr[3:2] & lfsr[7:6]; end
                    2: begin iv = lfsr[1:0] & lfsr[5:4]; ordy = lfsr[3:2] | lfsr[7:6]; end
                    default: begin iv = {1'b0, lfsr[0]} << lfsr[8]; ordy = lfsr[3:2]; end
                endcase
                step(iv, ordy);
            end
        end

        repeat (10) step(2'b00, 2'b11);
        chk("R8", "addresses delivered vs accepted", 32'(rcvd), 32'(sent));
        chk("R8", "queues drained", 32'(dn_valid), 32'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule